// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This unit takes two IEEE-754 operands and returns the smaller or the larger of them. It works in single precision (32-bit, carried in the low half of the 64-bit operand ports) or double precision (64-bit). Two select inputs, sampled with a valid strobe, pick the format and whether the minimum or the maximum is wanted. The result is registered and appears one cycle after the strobe.

NaN inputs are suppressed. When exactly one operand is NaN, the other operand is returned unchanged. When both operands are NaN, a canonical all-ones word is returned. A signalling NaN on either input raises a sticky invalid flag. Quiet NaNs raise nothing. The flag vector keeps its bits until an explicit clear input is asserted. Signed zeros are ordered so that -0 is below +0.

Top module: `fp_minmax_unit`

## Requirements
- R1: For two non-NaN operands, `max_i`=1 returns the greater and `max_i`=0 the lesser operand, bit for bit, under the usual numeric order including infinities. In single precision the upper 32 result bits are zero.
- R2: Zeros of opposite sign are ordered -0 < +0. The minimum of +0 and -0 is -0 and the maximum is +0, whichever port each zero is on.
- R3: If exactly one operand is NaN, the result is the other operand bit for bit.
- R4: If both operands are NaN, the result is all ones: 0xFFFFFFFF in the low half with zero upper half in single precision, and 0xFFFFFFFFFFFFFFFF in double precision.
- R5: A NaN is signalling when its exponent is all ones, its top mantissa bit is 0 and its other mantissa bits are not all zero. A signalling NaN on either operand sets invalid, including when the other operand is also NaN. Quiet NaNs and numbers set no flag.
- R6: `flags_o` places invalid at bit 1, divide-by-zero at bit 2, overflow at bit 3, underflow at bit 4 and inexact at bit 5. Bit 0 is reserved. This unit only ever raises bit 1, so every other bit stays 0.
- R7: Flags are sticky and OR-accumulate over valid operations. `clr_i` empties them at the next edge. An operation strobed in the same cycle as `clr_i` still contributes its own flags.
- R8: `res_o` and `res_vld_o` update one cycle after `valid_i`. `res_vld_o` is high for exactly that cycle. `res_o` holds its value while no operation is strobed.
- R9: In single precision, the upper 32 bits of both operand ports are ignored.
- R10: During and right after synchronous reset, `res_o`, `res_vld_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| max_i | input | 1 | 1 = maximum, 0 = minimum |
| clr_i | input | 1 | Clear the sticky flags |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| res_o | output | 64 | Registered result |
| res_vld_o | output | 1 | Result strobe, one cycle after valid_i |
| flags_o | output | 6 | Sticky exception flags, invalid at bit 1 |

## Verification
The bench builds the unit with its default field widths: an 8/23 split for single precision and an 11/52 split for double precision. With these widths, the exact encodings a software model would produce can be used as stimulus. That covers signalling and quiet NaNs in both formats, infinities, signed zeros and denormals. It also lets the bench put junk in the upper half of the ports during single-precision operations, to show that those bits are ignored. A behavioural model in the bench orders operands through a different mapping from the hardware's: it converts sign-magnitude to an unsigned key. The model's expected result, strobe and flags are compared on every clock.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int FLAG_W  = 6;
  localparam int FLG_INV = 1;
  localparam int FLG_DBZ = 2;
  localparam int FLG_OVF = 3;
  localparam int FLG_UNF = 4;
  localparam int FLG_INX = 5;

  typedef struct packed {
    logic nan;
    logic snan;
  } nan_class_t;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_ONES = 2'd2
  } pick_t;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output fmm_pkg::nan_class_t  cls_o
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic             exp_full;
  logic             man_nz;

  assign expo     = op_i[W-2 -: EXP_W];
  assign man      = op_i[MAN_W-1:0];
  assign exp_full = &expo;
  assign man_nz   = |man;

  always_comb begin
    cls_o.nan  = exp_full && man_nz;
    cls_o.snan = exp_full && !man[MAN_W-1] && |man[MAN_W-2:0];
  end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         max_i,
  output logic         take_b_o
);
  logic         a_neg, b_neg;
  logic [W-2:0] a_mag, b_mag;
  logic         mag_lt, mag_gt;
  logic         a_lt_b, b_lt_a;

  assign a_neg  = a_i[W-1];
  assign b_neg  = b_i[W-1];
  assign a_mag  = a_i[W-2:0];
  assign b_mag  = b_i[W-2:0];
  assign mag_lt = a_mag < b_mag;
  assign mag_gt = a_mag > b_mag;

  always_comb begin
    if (a_neg != b_neg) begin
      a_lt_b = a_neg;
      b_lt_a = b_neg;
    end else if (!a_neg) begin
      a_lt_b = mag_lt;
      b_lt_a = mag_gt;
    end else begin
      a_lt_b = mag_gt;
      b_lt_a = mag_lt;
    end
    take_b_o = max_i ? a_lt_b : b_lt_a;
  end
endmodule

// File: rtl/fmm_flags.sv
module fmm_flags #(
  parameter int FW = fmm_pkg::FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [FW-1:0] set_i,
  output logic [FW-1:0] flags_o
);
  logic [FW-1:0] sticky_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
    end else begin
      sticky_q <= (clr_i ? '0 : sticky_q) | (upd_i ? set_i : '0);
    end
  end

  assign flags_o = sticky_q;

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && sticky_q[fmm_pkg::FLG_INV]) |=> sticky_q[fmm_pkg::FLG_INV]);
  assert_clear_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(upd_i && |set_i)) |=> (sticky_q == '0));
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit #(
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               valid_i,
  input  logic                               dbl_i,
  input  logic                               max_i,
  input  logic                               clr_i,
  input  logic [DP_EXP+DP_MAN:0]             a_i,
  input  logic [DP_EXP+DP_MAN:0]             b_i,
  output logic [DP_EXP+DP_MAN:0]             res_o,
  output logic                               res_vld_o,
  output logic [fmm_pkg::FLAG_W-1:0]         flags_o
);
  import fmm_pkg::*;

  localparam int SP_W = SP_EXP + SP_MAN + 1;
  localparam int DP_W = DP_EXP + DP_MAN + 1;
  localparam int PAD_W = DP_W - SP_W;

  logic [DP_W-1:0] ops [2];
  nan_class_t sp_cls [2];
  nan_class_t dp_cls [2];
  nan_class_t act_cls [2];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fmm_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
      .op_i (ops[g][SP_W-1:0]),
      .cls_o(sp_cls[g])
    );
    fmm_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
      .op_i (ops[g]),
      .cls_o(dp_cls[g])
    );
    assign act_cls[g] = dbl_i ? dp_cls[g] : sp_cls[g];
  end

  logic sp_take_b, dp_take_b, take_b;

  fmm_order #(.W(SP_W)) u_ord_sp (
    .a_i     (a_i[SP_W-1:0]),
    .b_i     (b_i[SP_W-1:0]),
    .max_i   (max_i),
    .take_b_o(sp_take_b)
  );
  fmm_order #(.W(DP_W)) u_ord_dp (
    .a_i     (a_i),
    .b_i     (b_i),
    .max_i   (max_i),
    .take_b_o(dp_take_b)
  );
  assign take_b = dbl_i ? dp_take_b : sp_take_b;

  pick_t pick;
  always_comb begin
    if (act_cls[0].nan && act_cls[1].nan) pick = SEL_ONES;
    else if (act_cls[0].nan)              pick = SEL_B;
    else if (act_cls[1].nan)              pick = SEL_A;
    else if (take_b)                      pick = SEL_B;
    else                                  pick = SEL_A;
  end

  logic [DP_W-1:0] a_eff, b_eff, ones_eff, res_d;
  assign a_eff    = dbl_i ? a_i : {{PAD_W{1'b0}}, a_i[SP_W-1:0]};
  assign b_eff    = dbl_i ? b_i : {{PAD_W{1'b0}}, b_i[SP_W-1:0]};
  assign ones_eff = dbl_i ? {DP_W{1'b1}} : {{PAD_W{1'b0}}, {SP_W{1'b1}}};

  always_comb begin
    unique case (pick)
      SEL_B:    res_d = b_eff;
      SEL_ONES: res_d = ones_eff;
      default:  res_d = a_eff;
    endcase
  end

  logic [FLAG_W-1:0] new_flags;
  always_comb begin
    new_flags = '0;
    new_flags[FLG_INV] = act_cls[0].snan || act_cls[1].snan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  fmm_flags #(.FW(FLAG_W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .upd_i  (valid_i),
    .set_i  (new_flags),
    .flags_o(flags_o)
  );

  assert_nan_a_gives_b_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && act_cls[0].nan && !act_cls[1].nan) |=> (res_o == $past(b_eff)));
  assert_nan_b_gives_a_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && act_cls[1].nan && !act_cls[0].nan) |=> (res_o == $past(a_eff)));
  assert_both_nan_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && act_cls[0].nan && act_cls[1].nan) |=> (res_o == $past(ones_eff)));
  assert_snan_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (act_cls[0].snan || act_cls[1].snan)) |=> flags_o[FLG_INV]);
  assert_other_flags_zero_R6: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (flags_o[FLG_DBZ] == 1'b0 && flags_o[FLG_INX] == 1'b0 && flags_o[0] == 1'b0));
  assert_strobe_latency_R8: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> res_vld_o);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(res_o));
endmodule

// File: tb/fp_minmax_unit_tb.sv
module fp_minmax_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst, valid, dbl, mx, clr;
  logic [63:0] a, b;
  logic [63:0] res;
  logic        res_vld;
  logic [5:0]  flags;

  int total = 0;
  int bad = 0;
  bit done = 0;

  string drv_tag = "R10";
  string exp_tag = "R10";
  logic [63:0] exp_res;
  logic        exp_vld;
  logic [5:0]  exp_flags;

  always #5 clk = ~clk;

  fp_minmax_unit dut_i (
    .clk(clk), .rst(rst), .valid_i(valid), .dbl_i(dbl), .max_i(mx), .clr_i(clr),
    .a_i(a), .b_i(b), .res_o(res), .res_vld_o(res_vld), .flags_o(flags)
  );

  function automatic bit is_nan(input logic [63:0] x, input bit d);
    if (d) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [63:0] x, input bit d);
    if (d) return is_nan(x, 1) && !x[51];
    return is_nan(x, 0) && !x[22];
  endfunction

  function automatic logic [63:0] okey(input logic [63:0] x, input bit d);
    logic [63:0] v;
    v = d ? x : {x[31:0], 32'h0};
    return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y,
                                        input bit d, input bit m);
    logic [63:0] xa, ya;
    bit xn, yn;
    xa = d ? x : {32'h0, x[31:0]};
    ya = d ? y : {32'h0, y[31:0]};
    xn = is_nan(x, d);
    yn = is_nan(y, d);
    if (xn && yn) return d ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    if (xn) return ya;
    if (yn) return xa;
    if (m) return (okey(x, d) < okey(y, d)) ? ya : xa;
    return (okey(y, d) < okey(x, d)) ? ya : xa;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_res   <= '0;
      exp_vld   <= 1'b0;
      exp_flags <= '0;
      exp_tag   <= "R10";
    end else begin
      exp_vld <= valid;
      exp_tag <= valid ? drv_tag : "R8";
      if (valid) exp_res <= model(a, b, dbl, mx);
      exp_flags <= (clr ? 6'h0 : exp_flags) |
                   ((valid && (is_snan(a, dbl) || is_snan(b, dbl))) ? 6'b000010 : 6'h0);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (res !== exp_res || res_vld !== exp_vld || flags !== exp_flags) begin
        bad++;
        $display("FAIL %s: res=%h vld=%b flags=%b expected res=%h vld=%b flags=%b",
                 exp_tag, res, res_vld, flags, exp_res, exp_vld, exp_flags);
      end
    end
  end

  task automatic op(input logic [63:0] x, input logic [63:0] y, input bit d,
                    input bit m, input bit c, input string tag);
    @(negedge clk);
    a = x; b = y; dbl = d; mx = m; clr = c; valid = 1'b1; drv_tag = tag;
  endtask

  task automatic idle(input bit c, input string tag);
    @(negedge clk);
    valid = 1'b0; clr = c; drv_tag = tag;
  endtask

  localparam logic [63:0] S_ONE  = 64'h3F80_0000, S_TWO = 64'h4000_0000;
  localparam logic [63:0] S_NEG1 = 64'hBF80_0000, S_INF = 64'h7F80_0000;
  localparam logic [63:0] S_QN   = 64'h7FC0_0000, S_SN = 64'h7F80_0001;
  localparam logic [63:0] S_PZ   = 64'h0, S_NZ = 64'h8000_0000;
  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000, D_QN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_SN   = 64'h7FF7_0000_0000_0000, D_NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_NEG  = 64'hC000_0000_0000_0000, D_INF = 64'hFFF0_0000_0000_0000;

  function automatic logic [63:0] pick_val(input int k, input bit d);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (k)
      0: r = d ? D_QN : S_QN;
      1: r = d ? D_SN : S_SN;
      2: r = d ? 64'h0 : S_PZ;
      3: r = d ? D_NZ : S_NZ;
      4: r = d ? D_INF : S_INF;
      5: r = d ? D_ONE : S_ONE;
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    rst = 1'b1; valid = 0; dbl = 0; mx = 0; clr = 0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    drv_tag = "R10";
    rst = 1'b0;
    // R1 numeric ordering, both formats
    op(S_ONE, S_TWO, 0, 0, 0, "R1");
    op(S_ONE, S_TWO, 0, 1, 0, "R1");
    op(S_NEG1, S_INF, 0, 0, 0, "R1");
    op(D_NEG, D_ONE, 1, 1, 0, "R1");
    op(D_INF, D_NEG, 1, 0, 0, "R1");
    // R2 signed zeros
    op(S_PZ, S_NZ, 0, 0, 0, "R2");
    op(S_NZ, S_PZ, 0, 1, 0, "R2");
    op(D_NZ, 64'h0, 1, 0, 0, "R2");
    op(64'h0, D_NZ, 1, 1, 0, "R2");
    // R3 one NaN (quiet: no flag)
    op(S_QN, S_ONE, 0, 0, 0, "R3");
    op(S_ONE, S_QN, 0, 1, 0, "R3");
    op(D_QN, D_ONE, 1, 1, 0, "R3");
    // R4 both NaN, quiet
    op(S_QN, S_QN, 0, 0, 0, "R4");
    op(D_QN, D_QN, 1, 1, 0, "R4");
    idle(0, "R6");
    // R5 signalling NaN raises invalid
    op(D_SN, D_ONE, 1, 0, 0, "R5");
    op(D_SN, D_SN, 1, 1, 0, "R5");
    // R7 sticky then clear, clear with simultaneous op
    idle(0, "R7");
    idle(1, "R7");
    op(S_SN, S_ONE, 0, 1, 1, "R7");
    idle(0, "R7");
    op(S_ONE, S_TWO, 0, 0, 1, "R7");
    // R8 hold
    idle(0, "R8");
    idle(0, "R8");
    // R9 upper bits ignored in single precision
    op(64'hFFF0_0000_3F80_0000, 64'h7FF0_0001_4000_0000, 0, 1, 0, "R9");
    op(64'hDEAD_BEEF_7FC0_0000, 64'h1234_5678_BF80_0000, 0, 0, 0, "R9");
    op(64'hFFFF_FFFF_0000_0001, 64'h0000_0000_3460_01D6, 0, 0, 0, "R9");
    // mixed random sweep
    for (int i = 0; i < 300; i++) begin
      bit d;
      d = $urandom_range(0, 1);
      if ($urandom_range(0, 4) == 0) idle($urandom_range(0, 7) == 0, "R7");
      else op(pick_val($urandom_range(0, 9), d), pick_val($urandom_range(0, 9), d), d,
              $urandom_range(0, 1), $urandom_range(0, 9) == 0, "R1");
    end
    idle(0, "R8");
    idle(0, "R8");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule